// File: doc/BRIEF.md
# Two-Read Byte Result Port

This block keeps the most recent 10-bit conversion result and lets a host with an 8-bit bus fetch it in two read accesses. The upper byte comes out first. The second access returns the two leftover low bits, packed at the top of the byte. An end-of-conversion strobe with the new value loads the result register. Every load sends the next read back to the upper byte, so a host that starts reading after a new result always gets the bytes in order.

The host strobes are modelled as synchronous active-low chip-select and read inputs, sampled on the clock. While an access is active, the port drives its data bus and raises an output-enable flag. The byte for an access is captured when the access starts and stays unchanged until it ends, even if a new result arrives in the middle. The read pointer moves forward when the read strobe is released. The port has no link to the converter core's power state, so reads keep working while the core is powered down.

Top module: `byte_result_port`

## Requirements
- R1: After reset, `dout_oe` is 0, `dout` is 0, and the first read returns the upper byte of an all-zero result (0x00).
- R2: The result register loads `res_data` on every clock edge at which `res_valid` is 1, and at no other time.
- R3: `dout_oe` is 1 in the cycle after an edge at which `cs_n` and `rd_n` were both sampled low, and 0 in the cycle after an edge at which either was sampled high.
- R4: The first read after a result load returns result bits [9:2] on `dout[7:0]`.
- R5: The second read returns result bits [1:0] on `dout[7:6]`, with `dout[5:0]` equal to 0.
- R6: A third read returns the upper byte again, and later reads keep alternating upper byte, then low bits.
- R7: A result load makes the next read return the upper byte, however many reads came before it.
- R8: While `dout_oe` is 0, `dout` is all zeros.
- R9: If a result is loaded while a read is active, the byte on `dout` stays unchanged until that read ends, and the next read returns the upper byte of the new result.
- R10: A cycle with only one of `cs_n` or `rd_n` low neither drives the bus nor moves the read pointer.
- R11: If a result load and the start of a read happen on the same edge, that read returns the upper byte of the new result, and the read after it returns the new result's low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_valid | input | 1 | End-of-conversion strobe; loads `res_data` |
| res_data | input | RES_W (10) | New conversion result |
| cs_n | input | 1 | Chip select from the host, active low |
| rd_n | input | 1 | Read strobe from the host, active low |
| dout | output | BUS_W (8) | Read data; zero whenever it is not driven |
| dout_oe | output | 1 | High while the port drives `dout` |

## Verification
The bench builds the block with its default widths: a 10-bit result on an 8-bit bus, which leaves 2 bits for the second read. With these widths the bench can rebuild both bytes with plain division and remainder, and compare them against a table of results that includes all-ones, all-zeros and alternating patterns. The directed tests cover the cases where the pointer logic can go wrong: a load in the middle of a read, a load on the same edge as the start of a read, and a read strobe without chip select.

// File: rtl/brp_pkg.sv
package brp_pkg;
  // Which part of the held result the next read returns.
  typedef enum logic {
    PTR_MSB = 1'b0,
    PTR_LSB = 1'b1
  } rd_ptr_e;
endpackage

// File: rtl/brp_result_reg.sv
module brp_result_reg #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RES_W-1:0] d,
  output logic [RES_W-1:0] q,
  output logic [RES_W-1:0] q_next
);
  // Value the register will hold after this edge; the output stage
  // captures from it so a load and a read start can share an edge.
  always_comb q_next = load ? d : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end
endmodule

// File: rtl/brp_read_seq.sv
module brp_read_seq
  import brp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cs_n,
  input  logic    rd_n,
  input  logic    new_res,
  output logic    access_q,
  output logic    rd_start,
  output logic    rd_end,
  output rd_ptr_e sel_next,
  output rd_ptr_e ptr_q
);
  logic access_now;
  logic fresh_q;   // a result arrived after this read captured its byte

  always_comb begin
    access_now = !cs_n && !rd_n;
    rd_start   = access_now && !access_q;
    rd_end     = access_q && !access_now;
    // A load on the same edge as a read start makes that read take the MSB byte.
    sel_next   = new_res ? PTR_MSB : ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      access_q <= 1'b0;
      fresh_q  <= 1'b0;
      ptr_q    <= PTR_MSB;
    end else begin
      access_q <= access_now;
      if (rd_end)
        fresh_q <= 1'b0;
      else if (new_res && access_q)
        fresh_q <= 1'b1;

      if (new_res)
        ptr_q <= PTR_MSB;
      else if (rd_end && !fresh_q)
        ptr_q <= (ptr_q == PTR_MSB) ? PTR_LSB : PTR_MSB;
    end
  end
endmodule

// File: rtl/brp_out_stage.sv
module brp_out_stage
  import brp_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             drive,
  input  rd_ptr_e          sel,
  input  logic [RES_W-1:0] src,
  output logic [BUS_W-1:0] dout,
  output logic             dout_oe
);
  localparam int LSB_W = RES_W - BUS_W;

  function automatic logic [BUS_W-1:0] msb_part(input logic [RES_W-1:0] r);
    return r[RES_W-1 -: BUS_W];
  endfunction

  function automatic logic [BUS_W-1:0] lsb_part(input logic [RES_W-1:0] r);
    logic [BUS_W-1:0] b;
    b = '0;
    b[BUS_W-1 -: LSB_W] = r[LSB_W-1:0];
    return b;
  endfunction

  logic [BUS_W-1:0] byte_q;
  logic [BUS_W-1:0] byte_sel;

  always_comb byte_sel = (sel == PTR_MSB) ? msb_part(src) : lsb_part(src);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       byte_q <= '0;
    else if (capture) byte_q <= byte_sel;
  end

  always_comb begin
    dout_oe = drive;
    dout    = drive ? byte_q : '0;
  end
endmodule

// File: rtl/byte_result_port.sv
module byte_result_port
  import brp_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  input  logic             cs_n,
  input  logic             rd_n,
  output logic [BUS_W-1:0] dout,
  output logic             dout_oe
);
  logic [RES_W-1:0] held_q;
  logic [RES_W-1:0] held_next;
  logic             access_q;
  logic             rd_start;
  logic             rd_end;
  rd_ptr_e          sel_next;
  rd_ptr_e          ptr_q;
  logic             ptr_lsb_w;   // named for the checker

  assign ptr_lsb_w = (ptr_q == PTR_LSB);

  brp_result_reg #(.RES_W(RES_W)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (res_valid),
    .d      (res_data),
    .q      (held_q),
    .q_next (held_next)
  );

  brp_read_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .new_res  (res_valid),
    .access_q (access_q),
    .rd_start (rd_start),
    .rd_end   (rd_end),
    .sel_next (sel_next),
    .ptr_q    (ptr_q)
  );

  brp_out_stage #(.RES_W(RES_W), .BUS_W(BUS_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (rd_start),
    .drive   (access_q),
    .sel     (sel_next),
    .src     (held_next),
    .dout    (dout),
    .dout_oe (dout_oe)
  );

  logic unused_w;
  assign unused_w = ^{held_q, rd_end};
endmodule

// File: rtl/brp_checker.sv
module brp_checker #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             res_valid,
  input logic             cs_n,
  input logic             rd_n,
  input logic [BUS_W-1:0] dout,
  input logic             dout_oe,
  input logic             ptr_lsb
);
  assert_oe_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n) |=> dout_oe);

  assert_oe_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |=> !dout_oe);

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> (dout == '0));

  assert_byte_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && $past(dout_oe)) |-> $stable(dout));

  assert_load_rewinds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !ptr_lsb);

  assert_partial_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((cs_n != rd_n) && !dout_oe && !res_valid) |=> $stable(ptr_lsb));
endmodule

bind byte_result_port brp_checker #(.BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .res_valid (res_valid),
  .cs_n      (cs_n),
  .rd_n      (rd_n),
  .dout      (dout),
  .dout_oe   (dout_oe),
  .ptr_lsb   (ptr_lsb_w)
);

// File: tb/byte_result_port_tb.sv
module byte_result_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       res_valid = 1'b0;
  logic [9:0] res_data = '0;
  logic       cs_n = 1'b1;
  logic       rd_n = 1'b1;
  logic [7:0] dout;
  logic       dout_oe;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  byte_result_port u_dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .cs_n(cs_n), .rd_n(rd_n), .dout(dout), .dout_oe(dout_oe)
  );

  localparam int NV = 8;
  localparam logic [9:0] VEC [NV] = '{10'h3FF, 10'h000, 10'h2AA, 10'h155,
                                      10'h001, 10'h302, 10'h0FD, 10'h23C};

  function automatic logic [7:0] want_hi(input int v);
    return 8'(v / 4);
  endfunction
  function automatic logic [7:0] want_lo(input int v);
    return 8'((v % 4) * 64);
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [9:0] v);
    @(negedge clk); res_valid = 1'b1; res_data = v;
    @(negedge clk); res_valid = 1'b0;
  endtask

  // One full read: byte is checked while active, idle bus checked after.
  task automatic do_read(input string req, input logic [7:0] exp);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    check(req, {dout_oe, dout}, {1'b1, exp});
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    check("R8", {dout_oe, dout}, 9'h000);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {dout_oe, dout}, 9'h000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {dout_oe, dout}, 9'h000);
    do_read("R1", 8'h00);

    // Table walk: R2 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      load(VEC[i]);
      do_read("R4", want_hi(int'(VEC[i])));
      do_read("R5", want_lo(int'(VEC[i])));
      do_read("R6", want_hi(int'(VEC[i])));
      do_read("R6", want_lo(int'(VEC[i])));
    end

    // R7: rewind after an odd number of reads
    load(10'h1C7);
    do_read("R7", want_hi(10'h1C7));
    load(10'h2E5);
    do_read("R7", want_hi(10'h2E5));
    do_read("R2", want_lo(10'h2E5));

    // R10: partial strobes do not drive the bus or advance the pointer
    load(10'h0B6);
    @(negedge clk); rd_n = 1'b0;
    @(negedge clk); check("R10", {dout_oe, dout}, 9'h000);
    rd_n = 1'b1; cs_n = 1'b0;
    @(negedge clk); check("R10", {dout_oe, dout}, 9'h000);
    cs_n = 1'b1;
    @(negedge clk);
    do_read("R10", want_hi(10'h0B6));

    // R9: load during an active read
    load(10'h3C3);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk); check("R9", {dout_oe, dout}, {1'b1, want_hi(10'h3C3)});
    res_valid = 1'b1; res_data = 10'h04E;
    @(negedge clk); res_valid = 1'b0;
    check("R9", {dout_oe, dout}, {1'b1, want_hi(10'h3C3)});
    @(negedge clk); check("R9", {dout_oe, dout}, {1'b1, want_hi(10'h3C3)});
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    do_read("R9", want_hi(10'h04E));
    do_read("R9", want_lo(10'h04E));

    // R11: load on the same edge as the read start
    load(10'h111);
    do_read("R11", want_hi(10'h111));
    @(negedge clk); res_valid = 1'b1; res_data = 10'h2F7; cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk); res_valid = 1'b0;
    check("R11", {dout_oe, dout}, {1'b1, want_hi(10'h2F7)});
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    do_read("R11", want_lo(10'h2F7));

    // R1: reset mid-sequence returns to idle and MSB pointer
    do_read("R6", want_hi(10'h2F7));
    rst_n = 1'b0;
    @(negedge clk); check("R1", {dout_oe, dout}, 9'h000);
    rst_n = 1'b1;
    do_read("R1", 8'h00);

    finish_run();
  end
endmodule